// File: doc/BRIEF.md
# Daisy-Chain Module Identification Unit

This unit sits on a peripheral module and lets a bus master find it and give it a base I/O address without any jumpers or fixed decoding. Modules are wired in a chain. Each one takes a chain input from its neighbour on the master's side and drives a chain output to the next module. After reset every chain output is low. Only the module whose chain input is high and whose own chain output is still low answers at I/O port 0.

The master reads port 0 to get that module's identity word. It then writes port 0 with the base byte it has chosen. The module stores the byte as the upper half of its 16-bit address window, raises its chain output and goes quiet on port 0, so the next module in the chain becomes the one that answers. Once a module holds a base, it decodes every access whose upper address byte matches that base. It raises a select and passes the lower byte on as the register offset for the device logic behind it. An access of any kind to a fixed global reset port returns every module to the unconfigured state.

All responses are registered and appear in the cycle after the access strobe.

Top module: `chain_id_unit`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, chain_out_o, ack_o and sel_o are low and rdata_o and reg_off_o are zero.
- R2: chain_out_o is high exactly while the module is configured. It rises in the cycle after a port-0 write (io_addr_i == 16'h0000, io_we_i high) that is strobed while chain_in_i is high and the module is unconfigured.
- R3: If chain_in_i is low at a clock edge, the module is unconfigured and its stored base is zero after that edge. This overrides a port-0 write or any other access in the same cycle.
- R4: A port-0 read strobed while chain_in_i is high and the module is unconfigured gives ack_o high and rdata_o equal to type_word_i in the next cycle. In every other cycle rdata_o is zero.
- R5: A port-0 write strobed in that same answering state gives ack_o in the next cycle and stores io_wdata_i[7:0] as the base byte. Once the module is configured, port-0 accesses give no ack_o and leave the base unchanged.
- R6: While configured, an access whose io_addr_i[15:8] equals the base byte (other than the global reset port) gives sel_o high and reg_off_o equal to io_addr_i[7:0] in the next cycle. Otherwise sel_o is low and reg_off_o is zero.
- R7: An access, read or write, to the global reset port (parameter GRST_PORT, default 16'hFFFE) gives no sel_o and leaves the module unconfigured after that edge. The module then answers port 0 again.
- R8: While chain_in_i is low, no access produces ack_o.

Default parameters: 16-bit address and data, 8-bit base byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_in_i | input | 1 | Chain enable from the neighbour on the master's side |
| chain_out_o | output | 1 | Chain enable to the next module; high once configured |
| io_valid_i | input | 1 | One-cycle I/O access strobe |
| io_we_i | input | 1 | Access is a write |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 16 | Write data |
| type_word_i | input | 16 | Identity word returned on a port-0 read |
| ack_o | output | 1 | Identification access answered |
| rdata_o | output | 16 | Read data for an identification read, else zero |
| sel_o | output | 1 | Access hit the module's configured window |
| reg_off_o | output | 8 | Local register offset of a selected access |

## Verification
Two events can land on the same clock edge: the chain input falling, and a port-0 write that would configure the module. The bench drives a port-0 write with chain_in_i held low in that same cycle. The reference model expects chain_out_o to stay low, no ack_o, and the base to read back as zero. The base is brought out through sel_o: a later access to window 00 selects the module only once it has been reconfigured. A global reset access aimed at a configured module whose base byte is FF also overlaps the window decode. The bench expects no select in that case and expects port 0 to answer again afterwards.

// File: rtl/chain_id_pkg.sv
package chain_id_pkg;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned BASE_W = 8;
  localparam int unsigned OFF_W = ADDR_W - BASE_W;

  typedef struct packed {
    logic              valid;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } io_req_t;
endpackage

// File: rtl/chain_id_state.sv
module chain_id_state
  import chain_id_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chain_in_i,
  input  logic              id_wr_i,
  input  logic              grst_i,
  input  logic [BASE_W-1:0] base_in_i,
  output logic              cfg_o,
  output logic [BASE_W-1:0] base_o
);
  logic              cfg_q;
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= 1'b0;
      base_q <= '0;
    end else if (!chain_in_i || grst_i) begin
      cfg_q  <= 1'b0;
      base_q <= '0;
    end else if (id_wr_i) begin
      cfg_q  <= 1'b1;
      base_q <= base_in_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign base_o = base_q;

  AST_CHAIN_LOW_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_in_i |=> (!cfg_q && base_q == '0)); // R3
  AST_GRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grst_i |=> !cfg_q); // R7
  AST_CFG_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_q) |-> $past(id_wr_i && chain_in_i)); // R2
  AST_BASE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q && chain_in_i && !grst_i) |=> $stable(base_q)); // R5
endmodule

// File: rtl/chain_id_decode.sv
module chain_id_decode
  import chain_id_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  io_req_t           req_i,
  input  logic              answer_i,
  input  logic              win_ok_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [DATA_W-1:0] type_word_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sel_o,
  output logic [OFF_W-1:0]  reg_off_o
);
  logic              id_hit, win_hit;
  logic              ack_q, sel_q;
  logic [DATA_W-1:0] rdata_q;
  logic [OFF_W-1:0]  off_q;

  assign id_hit  = req_i.valid && answer_i && (req_i.addr == '0);
  assign win_hit = req_i.valid && win_ok_i && (req_i.addr[ADDR_W-1:OFF_W] == base_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      sel_q   <= 1'b0;
      off_q   <= '0;
    end else begin
      ack_q   <= id_hit;
      rdata_q <= (id_hit && !req_i.we) ? type_word_i : '0;
      sel_q   <= win_hit;
      off_q   <= win_hit ? req_i.addr[OFF_W-1:0] : '0;
    end
  end

  assign ack_o     = ack_q;
  assign rdata_o   = rdata_q;
  assign sel_o     = sel_q;
  assign reg_off_o = off_q;

  AST_ACK_NEEDS_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> $past(answer_i)); // R8
  AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_q |-> (rdata_q == '0)); // R4
  AST_ID_SEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_q && sel_q)); // R6
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_q |-> (off_q == '0)); // R6
endmodule

// File: rtl/chain_id_unit.sv
module chain_id_unit
  import chain_id_pkg::*;
#(
  parameter logic [ADDR_W-1:0] GRST_PORT = 16'hFFFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chain_in_i,
  output logic              chain_out_o,
  input  logic              io_valid_i,
  input  logic              io_we_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  input  logic [DATA_W-1:0] type_word_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sel_o,
  output logic [OFF_W-1:0]  reg_off_o
);
  io_req_t           req;
  logic              cfg, answer, grst, id_wr, win_ok;
  logic [BASE_W-1:0] base;

  assign req    = '{valid: io_valid_i, we: io_we_i, addr: io_addr_i, wdata: io_wdata_i};
  assign answer = chain_in_i && !cfg;
  assign grst   = io_valid_i && (io_addr_i == GRST_PORT);
  assign id_wr  = io_valid_i && io_we_i && answer && (io_addr_i == '0);
  assign win_ok = cfg && chain_in_i && !grst;

  chain_id_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chain_in_i (chain_in_i),
    .id_wr_i    (id_wr),
    .grst_i     (grst),
    .base_in_i  (io_wdata_i[BASE_W-1:0]),
    .cfg_o      (cfg),
    .base_o     (base)
  );

  chain_id_decode u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .answer_i    (answer),
    .win_ok_i    (win_ok),
    .base_i      (base),
    .type_word_i (type_word_i),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o),
    .sel_o       (sel_o),
    .reg_off_o   (reg_off_o)
  );

  assign chain_out_o = cfg;

  AST_OUT_LOW_UNTIL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chain_out_o) |-> $past(io_valid_i && io_we_i && io_addr_i == '0)); // R2
  AST_NO_ACK_WHEN_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(chain_out_o) |-> !ack_o); // R5
endmodule

// File: tb/chain_id_unit_bench.sv
module chain_id_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chain_in = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] tword = 16'hA5C3;
  logic        chain_out, ack, sel;
  logic [15:0] rdata;
  logic [7:0]  off;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chain_id_unit u_chain_id_unit (
    .clk_i(clk), .rst_ni(rst_n), .chain_in_i(chain_in), .chain_out_o(chain_out),
    .io_valid_i(valid), .io_we_i(we), .io_addr_i(addr), .io_wdata_i(wdata),
    .type_word_i(tword), .ack_o(ack), .rdata_o(rdata), .sel_o(sel), .reg_off_o(off)
  );

  // behavioural reference model
  bit        m_cfg;
  int        m_base;
  bit        e_ack, e_sel;
  int        e_rdata, e_off;
  bit        cmp_en = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg <= 0; m_base <= 0; e_ack <= 0; e_sel <= 0; e_rdata <= 0; e_off <= 0;
    end else begin
      bit is_id, is_rst, is_win;
      is_id  = valid && chain_in && !m_cfg && addr == 16'h0000;
      is_rst = valid && addr == 16'hFFFE;
      is_win = valid && chain_in && m_cfg && !is_rst && int'(addr >> 8) == m_base;
      e_ack   <= is_id;
      e_rdata <= (is_id && !we) ? int'(tword) : 0;
      e_sel   <= is_win;
      e_off   <= is_win ? int'(addr & 16'h00FF) : 0;
      if (!chain_in || is_rst) begin
        m_cfg <= 0; m_base <= 0;
      end else if (is_id && we) begin
        m_cfg <= 1; m_base <= int'(wdata & 16'h00FF);
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cmp_en && rst_n) begin
      chk("R2 chain_out", int'(chain_out), int'(m_cfg));
      chk("R4 ack", int'(ack), int'(e_ack));
      chk("R4 rdata", int'(rdata), e_rdata);
      chk("R6 sel", int'(sel), int'(e_sel));
      chk("R6 reg_off", int'(off), e_off);
    end
  end

  task automatic acc(bit w, logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    valid = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    valid = 0; we = 0;
    #1;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #3;
    chk("R1 chain_out in reset", int'(chain_out), 0);
    chk("R1 ack in reset", int'(ack), 0);
    chk("R1 sel in reset", int'(sel), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata after reset", int'(rdata), 0);
    chk("R1 reg_off after reset", int'(off), 0);
    cmp_en = 1;

    // R8: chain low, no answer
    acc(0, 16'h0000, 0);
    chk("R8 no ack chain low", int'(ack), 0);
    // R4: identity read
    chain_in = 1;
    acc(0, 16'h0000, 0);
    chk("R4 ack", int'(ack), 1);
    chk("R4 type word", int'(rdata), int'(tword));
    // R5: configure base 34
    acc(1, 16'h0000, 16'h1234);
    chk("R5 ack on write", int'(ack), 1);
    chk("R2 chain_out high", int'(chain_out), 1);
    acc(0, 16'h0000, 0);
    chk("R5 port0 ignored", int'(ack), 0);
    acc(1, 16'h0000, 16'h0077);
    // R6: decode
    acc(0, 16'h3456, 0);
    chk("R6 sel hit", int'(sel), 1);
    chk("R6 offset", int'(off), 16'h56);
    acc(1, 16'h3556, 0);
    chk("R6 sel miss", int'(sel), 0);
    // R7: global reset with base FF overlapping
    acc(1, 16'hFFFE, 0);
    acc(1, 16'h0000, 16'h00FF);
    chk("R7 reconfigured", int'(chain_out), 1);
    acc(0, 16'hFFFE, 0);
    chk("R7 no sel on reset port", int'(sel), 0);
    chk("R7 unconfigured", int'(chain_out), 0);
    acc(0, 16'h0000, 0);
    chk("R7 answers again", int'(ack), 1);
    // R3: chain drop in same cycle as configuring write
    @(negedge clk);
    chain_in = 0; valid = 1; we = 1; addr = 16'h0000; wdata = 16'h0000;
    @(negedge clk);
    valid = 0; we = 0;
    chk("R3 clear wins chain_out", int'(chain_out), 0);
    chk("R3 clear wins ack", int'(ack), 0);
    chain_in = 1;
    acc(0, 16'h0011, 0);
    chk("R3 base not taken", int'(sel), 0);
    acc(1, 16'h0000, 16'h0000);
    acc(0, 16'h0011, 0);
    chk("R6 base 00 window", int'(sel), 1);
    @(negedge clk); chain_in = 0;
    @(negedge clk); chain_in = 1;
    chk("R3 chain drop clears", int'(chain_out), 0);
    // random traffic checked by the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      valid = $urandom_range(0, 3) != 0;
      we = $urandom_range(0, 1) != 0;
      case ($urandom_range(0, 4))
        0: addr = 16'h0000;
        1: addr = 16'hFFFE;
        2: addr = {8'($urandom_range(0, 3)), 8'($urandom)};
        3: addr = 16'hFF00 | 16'($urandom_range(0, 255));
        default: addr = 16'($urandom);
      endcase
      wdata = 16'($urandom_range(0, 3)) | 16'hAB00;
      chain_in = $urandom_range(0, 15) != 0;
    end
    @(negedge clk); valid = 0;
    @(negedge clk);
    done = 1;
    summary();
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule